// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Timer

This block generates motor-drive style PWM. An up/down counter runs a symmetric triangle between zero and a period value. Each of three phases compares the count against its own compare value and produces a complementary pair of outputs, with a programmable dead band between them. That gives six output pins in total. A divided count clock sets the triangle slope. A culled interrupt marks the triangle valleys.

Software writes the period and the three compare values into buffer registers. While the timer is stopped, each buffer reaches its active register on the next clock. While the timer runs, a buffer is copied only at a period interrupt, and only if its transfer-enable bit is set. Two illegal settings raise an error output: a zero period, and a compare value above the period.

Top module: `cpwm_timer`

## Requirements
- R1: The write port decodes these addresses:
  - address 0 is control;
  - address 1 is the period buffer;
  - address 2 is the dead-time register;
  - addresses 4, 5 and 6 are the phase 0, 1 and 2 compare buffers.

  The control bits are:
  - [1:0] mode, where 2'b10 selects the triangle;
  - [4:2] prescale select;
  - [7:5] cull;
  - [8] run;
  - [9] dead-time off;
  - [10] active-low;
  - [11] compare transfer enable;
  - [12] period transfer enable.
- R2: When running with period value P, the counter holds each value for one count-clock period. It steps 0,1,…,P,P−1,…,1,0. The period interrupt is a one-cycle pulse in the cycle the counter returns to 0, so uncull'd pulses are 2·P count-clock periods apart.
- R3: The count clock is the base clock divided by 2^S, where S is the prescale select.
- R4: Phase i drives pwm_out[2i] and pwm_out[2i+1].
  - The raw phase signal is active while count ≥ compare.
  - pwm_out[2i] follows the raw signal and pwm_out[2i+1] follows its inverse.
  - Each turns on (dead-time register + 1) base-clock cycles late and turns off at once.
  - A pulse no longer than that delay produces no output.
  - The two outputs of a pair are never active together.
- R5: With dead-time off set to 1, both outputs of a pair follow the raw signal and its inverse with no delay.
- R6: A cull value N raises the period interrupt at one valley out of every N+1.
- R7: With active-low at 0 the pins are high when active; with active-low at 1 all six pins are inverted.
- R8: While stopped, all outputs are inactive and the counter rests at 0. A buffer write reaches its active register on the next clock.
- R9: While running, buffers are copied only at a period interrupt. The compare buffers are copied only if bit [11] is set. The period buffer is copied only if bit [12] is set.
- R10: cfg_err is set one clock after the active period is 0, or after any active compare value exceeds the active period.
- R11: With run set and any mode other than 2'b10, the timer counts nothing, all outputs are inactive and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | Three complementary pairs, phase i on bits 2i and 2i+1 |
| period_irq | output | 1 | Culled period interrupt pulse |
| cfg_err | output | 1 | Illegal period or compare setting |

## Verification
The counter-step and on-delay assertions assume the dead-time register and the dead-time off bit are held constant while the timer runs. The stimulus only reprograms them with run cleared. The valley assertion relies on the period never being zero while running. The stimulus writes a zero period only while stopped, and the error check on that write follows at once. Register writes always use mapped addresses, and each setup is followed by at least one full triangle before any measurement.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_PER  = 1;
  localparam int ADR_DEAD = 2;
  localparam int ADR_CH0  = 4;
  localparam int CTRL_W   = 13;
  localparam logic [1:0] MODE_TRI = 2'b10;

  typedef struct packed {
    logic       per_xfer;
    logic       chan_xfer;
    logic       act_low;
    logic       dt_off;
    logic       run;
    logic [2:0] cull;
    logic [2:0] presc;
    logic [1:0] mode;
  } ctrl_t;

  // count-clock enable: one base cycle out of every 2^sel
  function automatic logic presc_tick(input logic [6:0] div, input logic [2:0] sel);
    logic [6:0] mask;
    mask = (7'd1 << sel) - 7'd1;
    return (div & mask) == mask;
  endfunction

  // next value of the triangle counter
  function automatic logic [15:0] tri_next(input logic [15:0] cnt, input logic up,
                                           input logic [15:0] per);
    if (per == '0)             return '0;
    else if (up && cnt >= per) return cnt - 16'd1;
    else if (up || cnt == '0)  return cnt + 16'd1;
    else                       return cnt - 16'd1;
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  input  logic                   xfer_fire,
  output ctrl_t                  ctrl,
  output logic                   run,
  output logic [CW-1:0]          per_act,
  output logic [NCH-1:0][CW-1:0] cmp_act,
  output logic [CW-1:0]          dead
);
  logic [CW-1:0]          per_buf;
  logic [NCH-1:0][CW-1:0] cmp_buf;
  logic                   chan_load;
  logic                   per_load;

  assign run       = ctrl.run && (ctrl.mode == MODE_TRI);
  assign chan_load = !run || (xfer_fire && ctrl.chan_xfer);
  assign per_load  = !run || (xfer_fire && ctrl.per_xfer);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      dead    <= '0;
      per_buf <= '1;
      per_act <= '1;
    end else begin
      if (wr_en && wr_addr == AW'(ADR_CTRL)) ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == AW'(ADR_DEAD)) dead    <= wr_data;
      if (wr_en && wr_addr == AW'(ADR_PER))  per_buf <= wr_data;
      if (per_load)                          per_act <= per_buf;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_buf[i] <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(ADR_CH0 + i)) cmp_buf[i] <= wr_data;
        if (chan_load)                            cmp_act[i] <= cmp_buf[i];
      end
    end
  end

  // R9: without an enabled transfer, running compares hold
  a_r9_compare_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(xfer_fire && ctrl.chan_xfer)) |=> $stable(cmp_act));
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [2:0]    presc,
  input  logic [2:0]    cull,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          fire,
  output logic          irq
);
  logic [6:0]    div;
  logic [2:0]    cull_cnt;
  logic          up;
  logic          tick;
  logic          valley;
  logic [CW-1:0] cnt_nx;

  assign tick   = run && presc_tick(div, presc);
  assign cnt_nx = tri_next(cnt, up, per);
  assign valley = tick && cnt != '0 && cnt_nx == '0;
  assign fire   = valley && cull_cnt == cull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; cnt <= '0; up <= 1'b1; cull_cnt <= '0; irq <= 1'b0;
    end else if (!run) begin
      div <= '0; cnt <= '0; up <= 1'b1; cull_cnt <= '0; irq <= 1'b0;
    end else begin
      div <= div + 7'd1;
      irq <= fire;
      if (tick) begin
        cnt <= cnt_nx;
        if (up && cnt >= per && per != '0) up <= 1'b0;
        else if (!up && cnt == '0)         up <= 1'b1;
      end
      if (valley) cull_cnt <= fire ? 3'd0 : cull_cnt + 3'd1;
    end
  end

  // R2: the count moves by at most one step per cycle while running
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 ||
                             cnt == $past(cnt) - 1'b1));
  // R2: the interrupt pulse appears only at the valley
  a_r2_irq_at_valley: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));
  // R11: no interrupt while not running
  a_r11_no_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          raw,
  input  logic [CW-1:0] dt,
  input  logic          dt_off,
  output logic          pos,
  output logic          neg
);
  logic [1:0] leg_in;
  logic [1:0] leg_on;

  assign leg_in = {en && !raw, en && raw};

  for (genvar k = 0; k < 2; k++) begin : g_leg
    logic [CW:0] dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         dly <= '0;
      else if (!leg_in[k])                dly <= '0;
      else if (dly <= {1'b0, dt})         dly <= dly + 1'b1;
    end
    assign leg_on[k] = leg_in[k] && (dt_off || dly > {1'b0, dt});

    // R4: with dead time in use, a leg turns on only after its input was already high
    a_r4_delayed_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!dt_off && $past(!dt_off) && $rose(leg_on[k])) |-> $past(leg_in[k]));
  end

  assign pos = leg_on[0];
  assign neg = leg_on[1];

  // R4: a complementary pair never overlaps
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos && neg));
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [2*NCH-1:0] pwm_out,
  output logic           period_irq,
  output logic           cfg_err
);
  ctrl_t                  ctrl;
  logic                   run;
  logic [CW-1:0]          per_act;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [CW-1:0]          dead;
  logic [CW-1:0]          cnt;
  logic                   xfer_fire;
  logic [NCH-1:0]         raw;
  logic [NCH-1:0]         over;
  logic [NCH-1:0]         pos;
  logic [NCH-1:0]         neg;
  logic                   bad_cfg;

  cpwm_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_fire(xfer_fire), .ctrl(ctrl), .run(run), .per_act(per_act),
    .cmp_act(cmp_act), .dead(dead)
  );

  cpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(ctrl.presc), .cull(ctrl.cull),
    .per(per_act), .cnt(cnt), .fire(xfer_fire), .irq(period_irq)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_phase
    assign raw[i]  = cnt >= cmp_act[i];
    assign over[i] = cmp_act[i] > per_act;
    cpwm_deadband #(.CW(CW)) u_db (
      .clk(clk), .rst_n(rst_n), .en(run), .raw(raw[i]), .dt(dead),
      .dt_off(ctrl.dt_off), .pos(pos[i]), .neg(neg[i])
    );
    assign pwm_out[2*i]   = pos[i] ^ ctrl.act_low;
    assign pwm_out[2*i+1] = neg[i] ^ ctrl.act_low;
  end

  assign bad_cfg = (per_act == '0) || (|over);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= bad_cfg;
  end

  // R10: a zero active period is flagged on the following clock
  a_r10_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act == '0) |=> cfg_err);
  // R8: stopped timer keeps every pair inactive
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pos == '0 && neg == '0));
endmodule

// File: tb/cpwm_timer_test.sv
module cpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_out;
  logic        period_irq;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_irq(period_irq), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;  // 125 MHz

  // period, compare, dead, presc, cull, dt_off, act_low, exp_pos, exp_neg, exp_span
  localparam int NV = 6;
  localparam int VEC [NV][10] = '{
    '{20,  8, 3, 0, 0, 0, 0,  21,  11,  40},  // R2 R4 basic
    '{20,  8, 3, 2, 0, 0, 0,  96,  56, 160},  // R3 prescale /4
    '{10,  3, 0, 0, 2, 0, 0,  42,  12,  60},  // R6 cull 2
    '{16,  4, 5, 1, 0, 1, 0,  50,  14,  64},  // R5 dead time off
    '{12,  6, 2, 0, 0, 0, 1,  10,   8,  24},  // R7 active low
    '{12, 11, 4, 0, 0, 0, 0,   0,  16,  24}   // R4 short pulse swallowed
  };

  function automatic logic [15:0] mk_ctrl(int mode, int ps, int cull, int run, int off,
                                          int pol, int ce, int pe);
    logic [15:0] v;
    v = '0;
    v[1:0] = 2'(mode); v[4:2] = 3'(ps); v[7:5] = 3'(cull); v[8] = 1'(run);
    v[9] = 1'(off); v[10] = 1'(pol); v[11] = 1'(ce); v[12] = 1'(pe);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!period_irq);
  endtask

  // measure active-level cycles of pins 0,1,4,5 from this interrupt to the next
  task automatic measure(int pol, output int p0, output int n0, output int p2,
                         output int n2, output int span);
    logic act;
    act = (pol == 0);
    p0 = 0; n0 = 0; p2 = 0; n2 = 0; span = 0;
    do begin
      if (pwm_out[0] == act) p0++;
      if (pwm_out[1] == act) n0++;
      if (pwm_out[4] == act) p2++;
      if (pwm_out[5] == act) n2++;
      span++;
      @(negedge clk);
    end while (!period_irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, n0, p2, n2, span;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state: stopped, pins inactive (active high by default)
    check("R8 reset pins", int'(pwm_out), 0);
    check("R8 reset irq", int'(period_irq), 0);
    check("R10 reset err", int'(cfg_err), 0);

    // R10 / R8: stopped writes reach active registers at once
    wr(1, 16'd0); repeat (3) @(negedge clk);
    check("R10 zero period", int'(cfg_err), 1);
    wr(1, 16'd50); repeat (3) @(negedge clk);
    check("R10 period restored", int'(cfg_err), 0);
    wr(5, 16'd60); repeat (3) @(negedge clk);
    check("R8 R10 compare above period", int'(cfg_err), 1);
    wr(5, 16'd10); repeat (3) @(negedge clk);
    check("R8 compare restored", int'(cfg_err), 0);

    // R11: run set with a non-triangle mode
    wr(0, mk_ctrl(1, 0, 0, 1, 0, 0, 1, 1));
    begin
      int seen_irq = 0, seen_pin = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (period_irq) seen_irq++;
        if (pwm_out != 6'd0) seen_pin++;
      end
      check("R11 no irq", seen_irq, 0);
      check("R11 pins inactive", seen_pin, 0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr(0, mk_ctrl(2, VEC[v][3], VEC[v][4], 0, VEC[v][5], VEC[v][6], 1, 1));
      wr(1, 16'(VEC[v][0]));
      wr(2, 16'(VEC[v][2]));
      for (int ch = 0; ch < 3; ch++) wr(4 + ch, 16'(VEC[v][1]));
      wr(0, mk_ctrl(2, VEC[v][3], VEC[v][4], 1, VEC[v][5], VEC[v][6], 1, 1));
      wait_irq();
      wait_irq();
      measure(VEC[v][6], p0, n0, p2, n2, span);
      check($sformatf("R2 R3 R6 span row%0d", v), span, VEC[v][9]);
      check($sformatf("R1 R4 R5 R7 pos0 row%0d", v), p0, VEC[v][7]);
      check($sformatf("R1 R4 R5 R7 neg0 row%0d", v), n0, VEC[v][8]);
      check($sformatf("R4 pos2 row%0d", v), p2, VEC[v][7]);
      check($sformatf("R4 neg2 row%0d", v), n2, VEC[v][8]);
    end

    // R7 / R8: stop with active-low, pins all high
    wr(0, mk_ctrl(2, 0, 0, 0, 0, 1, 1, 1));
    repeat (2) @(negedge clk);
    check("R7 R8 stopped active-low pins", int'(pwm_out), 63);

    // R9: running transfers gated by the enable bits (row 0 setup)
    wr(0, mk_ctrl(2, 0, 0, 0, 0, 0, 1, 1));
    wr(1, 16'd20); wr(2, 16'd3);
    for (int ch = 0; ch < 3; ch++) wr(4 + ch, 16'd8);
    wr(0, mk_ctrl(2, 0, 0, 1, 0, 0, 0, 0));
    wr(4, 16'd30);
    wr(1, 16'd18);
    wait_irq(); wait_irq(); wait_irq();
    measure(0, p0, n0, p2, n2, span);
    check("R9 period held", span, 40);
    check("R9 compare held", p0, 21);
    check("R9 no error while held", int'(cfg_err), 0);
    wr(0, mk_ctrl(2, 0, 0, 1, 0, 0, 0, 1));
    wait_irq();
    measure(0, p0, n0, p2, n2, span);
    check("R9 period loaded", span, 36);
    check("R9 compare still held", int'(cfg_err), 0);
    wr(0, mk_ctrl(2, 0, 0, 1, 0, 0, 1, 1));
    wait_irq();
    repeat (2) @(negedge clk);
    check("R9 R10 compare loaded above period", int'(cfg_err), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule